// File: doc/BRIEF.md
# Exception Priority Arbiter

This block decides which pending exception or interrupt a small processor core should service next. It watches three fixed-rank exceptions (reset, non-maskable interrupt, hard fault), seven configurable system exceptions and 21 peripheral interrupts. Each configurable source has a 3-bit urgency level. A smaller level means more urgent. The level is loaded through a one-cycle write port. Fixed-rank sources always outrank every configurable level.

Each cycle, the block searches all eligible sources combinationally and registers the result. The result is the winning exception number, the winner's effective priority and a preemption request. The preemption request is raised when the winner may interrupt the handler that is running now. That comparison uses only the group bits of the level. A split-point input sets how many bits form the group part. The remaining low bits only order sources that are pending together.

Top module: `exc_arbiter`

## Requirements
- R1: Reset (number 1, priority -3), NMI (number 2, priority -2) and hard fault (number 3, priority -1) need no enable. They beat every configurable source, in the order reset, NMI, hard fault. The priority output is 4-bit two's complement, so these values read as 4'hD, 4'hE and 4'hF.
- R2: Configurable levels are 3 bits, and a smaller value wins. Every level resets to 0. Level 0 still ranks below the three fixed sources. A configurable winner reports its priority as {1'b0, level}.
- R3: A write with `cfg_we` high stores `cfg_lvl` into source `cfg_idx`. Indexes 0 to 6 are system sources at exception numbers 4, 5, 6, 11, 12, 14 and 15. Indexes 7 to 27 are peripheral interrupts 0 to 20 at exception numbers 16 to 36. Larger indexes store nothing. The new level is first used for arbitration in the cycle after the write edge.
- R4: When eligible configurable sources share a level, the lowest exception number wins.
- R5: A configurable source is eligible only while both its pending bit and its enable bit are 1.
- R6: With `grp_sel` = g (0 to 3), the group value of a level is level >> g. A negative fixed priority is its own group value.
- R7: `preempt` is 1 only when the result is valid and one of two conditions holds: `act_valid` is 0, or the winner's group value is strictly lower than the group value of `act_prio`. Equal groups do not preempt.
- R8: While the active priority is -2 (NMI running), only a pending reset raises `preempt`.
- R9: When no source is eligible, `take_valid`, `take_num`, `take_prio` and `preempt` are all 0.
- R10: All outputs are registered. They reflect the inputs sampled at the previous rising edge, and they are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_pend | input | 1 | Reset exception pending |
| nmi_pend | input | 1 | Non-maskable interrupt pending |
| hf_pend | input | 1 | Hard fault pending |
| sys_pend | input | 7 | System exception pending flags, index 0 to 6 |
| sys_en | input | 7 | System exception enables |
| irq_pend | input | 21 | Peripheral interrupt pending flags |
| irq_en | input | 21 | Peripheral interrupt enables |
| cfg_we | input | 1 | Level write strobe |
| cfg_idx | input | 5 | Source index for the write |
| cfg_lvl | input | 3 | Level to store |
| grp_sel | input | 2 | Group/subpriority split point |
| act_valid | input | 1 | A handler is running |
| act_prio | input | 4 | Priority of the running handler, two's complement |
| take_valid | output | 1 | An eligible source exists |
| take_num | output | 6 | Winning exception number |
| take_prio | output | 4 | Winner's priority, two's complement |
| preempt | output | 1 | Winner may interrupt the running handler |

## Verification
Every arbitration result appears one rising edge after its inputs are set up. The bench therefore drives each vector on a falling edge, lets one rising edge pass and compares on the next falling edge. A level write needs two edges before it is visible: one edge stores the level and the next registers the new result. The write test checks the output after the first edge, where it must still show the old winner, and again after the second edge. A separate check confirms that freshly applied inputs have not reached the outputs before any edge has occurred.

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int NUM_SYS = 7,
  parameter int NUM_IRQ = 21,
  parameter int LVL_W   = 3,
  parameter int GRP_W   = 2,
  parameter int IDX_W   = $clog2(NUM_SYS + NUM_IRQ),
  parameter int NUM_W   = $clog2(16 + NUM_IRQ + 1),
  parameter logic [NUM_SYS*8-1:0] SYS_POS = {8'd15, 8'd14, 8'd12, 8'd11, 8'd6, 8'd5, 8'd4}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_pend,
  input  logic               nmi_pend,
  input  logic               hf_pend,
  input  logic [NUM_SYS-1:0] sys_pend,
  input  logic [NUM_SYS-1:0] sys_en,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [LVL_W-1:0]   cfg_lvl,
  input  logic [GRP_W-1:0]   grp_sel,
  input  logic               act_valid,
  input  logic [LVL_W:0]     act_prio,
  output logic               take_valid,
  output logic [NUM_W-1:0]   take_num,
  output logic [LVL_W:0]     take_prio,
  output logic               preempt
);
  localparam int NSRC = NUM_SYS + NUM_IRQ;
  localparam logic [LVL_W:0] P_RST = -(LVL_W+1)'(3);
  localparam logic [LVL_W:0] P_NMI = -(LVL_W+1)'(2);
  localparam logic [LVL_W:0] P_HF  = -(LVL_W+1)'(1);

  logic [LVL_W-1:0] lvl_q [NSRC];
  logic [NSRC-1:0]  elig;
  logic             best_hit;
  logic [IDX_W-1:0] best_idx;
  logic [LVL_W-1:0] best_lvl;
  logic             nx_valid, nx_pre;
  logic [NUM_W-1:0] nx_num;
  logic [LVL_W:0]   nx_prio;

  assign elig = {irq_pend & irq_en, sys_pend & sys_en};

  function automatic logic [NUM_W-1:0] src_pos(input logic [IDX_W-1:0] i);
    if (int'(i) < NUM_SYS) return NUM_W'(SYS_POS[int'(i)*8 +: 8]);
    return NUM_W'(16 + int'(i) - NUM_SYS);
  endfunction

  function automatic logic signed [LVL_W:0] grp_of(input logic [LVL_W:0] p,
                                                   input logic [GRP_W-1:0] g);
    if (p[LVL_W]) return $signed(p);
    return $signed(p >> g);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
    end else if (cfg_we && int'(cfg_idx) < NSRC) begin
      lvl_q[cfg_idx] <= cfg_lvl;
    end
  end

  always_comb begin
    best_hit = 1'b0;
    best_idx = '0;
    best_lvl = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!best_hit || lvl_q[i] < best_lvl)) begin
        best_hit = 1'b1;
        best_idx = IDX_W'(i);
        best_lvl = lvl_q[i];
      end
    end
  end

  always_comb begin
    nx_valid = 1'b1;
    nx_num   = '0;
    nx_prio  = '0;
    if (rst_pend) begin
      nx_num = NUM_W'(1); nx_prio = P_RST;
    end else if (nmi_pend) begin
      nx_num = NUM_W'(2); nx_prio = P_NMI;
    end else if (hf_pend) begin
      nx_num = NUM_W'(3); nx_prio = P_HF;
    end else if (best_hit) begin
      nx_num = src_pos(best_idx); nx_prio = {1'b0, best_lvl};
    end else begin
      nx_valid = 1'b0;
    end
  end

  assign nx_pre = nx_valid &&
                  (!act_valid || (grp_of(nx_prio, grp_sel) < grp_of(act_prio, grp_sel)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_valid <= 1'b0;
      take_num   <= '0;
      take_prio  <= '0;
      preempt    <= 1'b0;
    end else begin
      take_valid <= nx_valid;
      take_num   <= nx_num;
      take_prio  <= nx_prio;
      preempt    <= nx_pre;
    end
  end

  // R1
  reset_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |=> (take_valid && take_num == NUM_W'(1) && take_prio == P_RST && preempt));

  // R1
  nmi_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pend && nmi_pend) |=> (take_num == NUM_W'(2) && take_prio == P_NMI));

  // R5
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pend && !nmi_pend && !hf_pend && (sys_pend & sys_en) == '0 &&
     (irq_pend & irq_en) == '0) |=> !take_valid);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_valid |-> (take_num == '0 && take_prio == '0 && !preempt));

  // R8
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_prio == P_NMI && !rst_pend) |=> !preempt);

  // R3
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && int'(cfg_idx) < NSRC) |=> lvl_q[$past(cfg_idx)] == $past(cfg_lvl));

  // R7
  pre_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> take_valid);
endmodule

// File: tb/sim_exc_arbiter.sv
module sim_exc_arbiter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_pend = 0, nmi_pend = 0, hf_pend = 0;
  logic [6:0] sys_pend = '0, sys_en = '0;
  logic [20:0] irq_pend = '0, irq_en = '0;
  logic cfg_we = 0;
  logic [4:0] cfg_idx = '0;
  logic [2:0] cfg_lvl = '0;
  logic [1:0] grp_sel = '0;
  logic act_valid = 0;
  logic [3:0] act_prio = '0;
  logic take_valid, preempt;
  logic [5:0] take_num;
  logic [3:0] take_prio;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_arbiter u0 (.clk, .rst_n, .rst_pend, .nmi_pend, .hf_pend, .sys_pend, .sys_en,
    .irq_pend, .irq_en, .cfg_we, .cfg_idx, .cfg_lvl, .grp_sel, .act_valid, .act_prio,
    .take_valid, .take_num, .take_prio, .preempt);

  localparam int NV = 18;
  localparam logic [2:0]  T_FIX [NV] = '{0,0,0,0,0,0,4,7,6,4,1,0,0,0,0,0,0,0};
  localparam logic [27:0] T_PEND[NV] = '{28'h0,28'h1,28'h1,28'hC,28'h180,28'h8000201,
    28'h200,28'h0,28'h0,28'h0,28'h0,28'h80,28'h80,28'h80,28'h200,28'h4,28'h200,28'h0};
  localparam logic [27:0] T_EN  [NV] = '{28'h0,28'h1,28'h0,28'hC,28'h180,28'h8000201,
    28'h200,28'h0,28'h0,28'h0,28'h0,28'h80,28'h80,28'h80,28'h200,28'h4,28'h200,28'h400};
  localparam logic [1:0]  T_GRP [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,2,1,3,0,0,0};
  localparam logic        T_AV  [NV] = '{0,0,0,0,0,0,0,0,0,1,1,1,1,1,1,1,1,0};
  localparam logic [3:0]  T_AP  [NV] = '{0,0,0,0,0,0,0,0,0,4'hE,4'hE,3,3,3,7,2,4'hF,0};
  localparam logic        T_EV  [NV] = '{0,1,0,1,1,1,1,1,1,1,1,1,1,1,1,1,1,0};
  localparam logic [5:0]  T_NUM [NV] = '{0,4,0,6,16,18,3,1,2,3,1,16,16,16,18,6,18,0};
  localparam logic [3:0]  T_PR  [NV] = '{0,3,0,2,1,0,4'hF,4'hD,4'hE,4'hF,4'hD,1,1,1,0,2,0,0};
  localparam logic        T_PRE [NV] = '{0,1,0,1,1,1,1,1,1,0,1,1,0,1,0,0,0,0};
  localparam string       T_REQ [NV] = '{"R9","R7","R5","R4","R4","R2","R1","R1","R1",
    "R8","R8","R7","R6","R6","R6","R7","R7","R5"};

  task automatic chk(string req, logic ev, logic [5:0] en, logic [3:0] ep, logic epre);
    nchk++;
    if (take_valid !== ev || take_num !== en || take_prio !== ep || preempt !== epre) begin
      nerr++;
      $display("FAIL %s: got v=%0b num=%0d prio=%h pre=%0b, want v=%0b num=%0d prio=%h pre=%0b",
               req, take_valid, take_num, take_prio, preempt, ev, en, ep, epre);
    end
  endtask

  task automatic wr(int idx, int lvl);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 5'(idx); cfg_lvl = 3'(lvl);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_src(logic [2:0] fx, logic [27:0] p, logic [27:0] e);
    {hf_pend, nmi_pend, rst_pend} = fx;
    sys_pend = p[6:0]; irq_pend = p[27:7];
    sys_en = e[6:0];   irq_en = e[27:7];
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    set_src(3'b111, 28'hFFFFFFF, 28'hFFFFFFF);
    repeat (3) @(negedge clk);
    chk("R10 reset", 0, 0, 0, 0);
    rst_n = 1;
    set_src(0, 0, 0);
    @(negedge clk);
    // R2: default level 0 everywhere; sys idx4 (#12) ties irq5 (#21)
    set_src(0, 28'h1010, 28'h1010);
    #1 chk("R10 no early change", 0, 0, 0, 0);
    @(negedge clk);
    chk("R2 default level", 1, 12, 0, 1);
    set_src(0, 0, 0);
    wr(0, 3); wr(1, 5); wr(2, 2); wr(3, 2); wr(4, 7); wr(5, 6); wr(6, 4);
    wr(7, 1); wr(8, 1); wr(9, 0); wr(10, 6); wr(27, 0);
    for (int k = 0; k < NV; k++) begin
      set_src(T_FIX[k], T_PEND[k], T_EN[k]);
      grp_sel = T_GRP[k]; act_valid = T_AV[k]; act_prio = T_AP[k];
      @(negedge clk);
      chk(T_REQ[k], T_EV[k], T_NUM[k], T_PR[k], T_PRE[k]);
    end
    // R3: irq3 (idx 10, #19) at 6 loses to irq0 (#16, level 1) until rewritten to 0
    grp_sel = 0; act_valid = 0; act_prio = 0;
    set_src(0, 28'h480, 28'h480);
    @(negedge clk);
    chk("R3 before write", 1, 16, 1, 1);
    cfg_we = 1; cfg_idx = 5'd10; cfg_lvl = 3'd0;
    @(negedge clk);
    cfg_we = 0;
    chk("R3 write latency", 1, 16, 1, 1);
    @(negedge clk);
    chk("R3 after write", 1, 19, 0, 1);
    // R3: index beyond 27 stores nothing
    wr(31, 7);
    @(negedge clk);
    chk("R3 out of range", 1, 19, 0, 1);
    // R10: reset clears registered outputs
    rst_n = 0;
    @(negedge clk);
    chk("R10 reset again", 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule